// File: doc/BRIEF.md
# Quiz Answer Arbiter with First-Press Lockout

This block decides which of several quiz contestants pressed first. Every contestant has one button input and one winner output. A single quizmaster level input controls the game: when it is held in its clear position every contestant latch is emptied and nothing can be latched. When it moves to the armed position the game opens, and the first contestant whose button is seen pressed is latched as the winner. From then on all other contestants are locked out until the quizmaster clears the game again.

Buttons and the quizmaster input arrive unsynchronized. Each button passes through a two-flop synchronizer. The quizmaster input also passes through a two-flop synchronizer and then through a stability filter. That filter accepts a new level only after the level has held for a programmable number of cycles, so contact bounce on the quizmaster switch can never clear a game or produce a winner on its own. Once a latch holds, bounce or release of that contestant's button has no effect, because the latch keeps its state.

Top module: `quiz_lockout`

## Requirements
- R1: After reset every bit of `win_o` and `locked_o` is 0, and the game is in the clear state.
- R2: Button level 1 means pressed. While the game is armed and no winner is held, a pressed button on player i sets bit i of `win_o` on the third rising clock edge after the press, two synchronizer stages and then the latch.
- R3: Once a winner is held in the armed game, releasing or bouncing that player's button leaves `win_o` unchanged.
- R4: While a winner is held, presses on any other player's button are ignored and `win_o` keeps its single bit.
- R5: If several buttons are first seen pressed in the same cycle, only the lowest-index player is latched. `win_o` never has more than one bit set.
- R6: `locked_o` is 1 exactly when some bit of `win_o` is 1. It behaves like the OR of all winner bits.
- R7: Quizmaster level 0 means clear and level 1 means armed. While the accepted level is clear, all winner bits go to 0 one cycle after acceptance, and pressed buttons latch nothing.
- R8: A new quizmaster level is accepted only after the synchronized input has differed from the accepted level for FILT_CYCLES consecutive cycles. A shorter excursion changes neither the game state nor `win_o`.
- R9: With no button pressed, toggling the quizmaster input in any pattern never sets a winner bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_i | input | NUM_PLAYERS | Raw contestant buttons, 1 = pressed |
| qm_i | input | 1 | Raw quizmaster switch, 1 = armed, 0 = clear |
| win_o | output | NUM_PLAYERS | One-hot winner indicator, bit i = player i |
| locked_o | output | 1 | High while a winner is held |

## Verification
Two contestants can be first seen pressed in the same cycle. A clear can also be accepted in the very cycle a button reaches its latch. The bench drives two buttons on the same clock phase and expects only the lower index to light, with `locked_o` rising once. It also bounces the quizmaster input for one cycle fewer than the filter window while a winner is held, and for exactly the window, expecting the winner to survive the first and be cleared by the second. Latency is judged edge by edge: a winner bit must still be 0 two edges after a press and must be 1 after the third.

// File: rtl/quiz_pkg.sv
package quiz_pkg;
    localparam int DEF_PLAYERS = 4;
    localparam int DEF_FILT    = 4;

    typedef enum logic {
        QM_CLEAR = 1'b0,
        QM_ARMED = 1'b1
    } qm_state_e;
endpackage

// File: rtl/quiz_sync.sv
module quiz_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        typedef struct packed {
            logic meta;
            logic stable;
        } sync_t;
        sync_t st_d, st_q;

        always_comb begin
            st_d.meta   = async_i[g];
            st_d.stable = st_q.meta;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign sync_o[g] = st_q.stable;
    end
endmodule

// File: rtl/quiz_qm_filter.sv
module quiz_qm_filter
    import quiz_pkg::*;
#(
    parameter int FILT_CYCLES = DEF_FILT
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      level_i,
    output qm_state_e state_o
);
    localparam int CW = $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

    typedef struct packed {
        qm_state_e       level;
        logic [CW-1:0]   cnt;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (level_i != logic'(st_q.level)) begin
            if (st_q.cnt == LAST) begin
                st_d.level = qm_state_e'(level_i);
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.level <= QM_CLEAR;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q.level;
endmodule

// File: rtl/quiz_arbiter.sv
module quiz_arbiter
    import quiz_pkg::*;
#(
    parameter int NUM_PLAYERS = DEF_PLAYERS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  qm_state_e              game_i,
    input  logic [NUM_PLAYERS-1:0] press_i,
    output logic [NUM_PLAYERS-1:0] win_o,
    output logic                   locked_o
);
    typedef struct packed {
        logic [NUM_PLAYERS-1:0] win;
    } arb_t;

    arb_t st_d, st_q;
    logic [NUM_PLAYERS-1:0] first_sel;
    logic                   any_held;

    // isolate lowest set bit: lowest index has priority
    assign first_sel = press_i & (~press_i + 1'b1);
    assign any_held  = |st_q.win;

    always_comb begin
        st_d = st_q;
        if (game_i == QM_CLEAR) begin
            st_d.win = '0;
        end else if (!any_held) begin
            st_d.win = first_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win_o    = st_q.win;
    assign locked_o = any_held;
endmodule

// File: rtl/quiz_lockout.sv
module quiz_lockout
    import quiz_pkg::*;
#(
    parameter int NUM_PLAYERS = DEF_PLAYERS,
    parameter int FILT_CYCLES = DEF_FILT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_PLAYERS-1:0] btn_i,
    input  logic                   qm_i,
    output logic [NUM_PLAYERS-1:0] win_o,
    output logic                   locked_o
);
    logic [NUM_PLAYERS-1:0] btn_sync;
    logic                   qm_sync;
    qm_state_e              game;
    logic                   armed;

    quiz_sync #(.W(NUM_PLAYERS)) u_btn_sync (
        .clk(clk), .rst_n(rst_n), .async_i(btn_i), .sync_o(btn_sync)
    );

    quiz_sync #(.W(1)) u_qm_sync (
        .clk(clk), .rst_n(rst_n), .async_i(qm_i), .sync_o(qm_sync)
    );

    quiz_qm_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filter (
        .clk(clk), .rst_n(rst_n), .level_i(qm_sync), .state_o(game)
    );

    quiz_arbiter #(.NUM_PLAYERS(NUM_PLAYERS)) u_arb (
        .clk(clk), .rst_n(rst_n), .game_i(game), .press_i(btn_sync),
        .win_o(win_o), .locked_o(locked_o)
    );

    assign armed = (game == QM_ARMED);
endmodule

// File: rtl/quiz_lockout_chk.sv
module quiz_lockout_chk #(
    parameter int NUM_PLAYERS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_PLAYERS-1:0] win,
    input logic                   locked,
    input logic                   armed
);
    a_r5_onehot_win: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win));

    a_r3_hold_while_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && armed) |=> $stable(win));

    a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> (win == '0));

    a_r9_win_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(armed));

    a_r6_locked_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($countones(win) == 1));
endmodule

bind quiz_lockout quiz_lockout_chk #(.NUM_PLAYERS(NUM_PLAYERS)) u_chk (
    .clk(clk), .rst_n(rst_n), .win(win_o), .locked(locked_o), .armed(armed)
);

// File: tb/quiz_lockout_tb.sv
module quiz_lockout_tb;
    localparam int NP   = 4;
    localparam int FILT = 4;
    localparam int SETTLE = FILT + 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] btn = '0;
    logic          qm = 1'b0;
    logic [NP-1:0] win;
    logic          locked;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    quiz_lockout #(.NUM_PLAYERS(NP), .FILT_CYCLES(FILT)) u_dut (
        .clk(clk), .rst_n(rst_n), .btn_i(btn), .qm_i(qm),
        .win_o(win), .locked_o(locked)
    );

    task automatic check(input string req, input logic [NP:0] act, input logic [NP:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_qm(input logic v);
        @(negedge clk); qm = v; cyc(SETTLE);
    endtask

    task automatic t_reset();
        check("R1 reset", {locked, win}, '0);
        cyc(3);
        btn = 4'b0001; cyc(5);
        check("R1 cleared after reset", {locked, win}, '0);
        btn = '0; cyc(3);
    endtask

    task automatic t_first_press();
        set_qm(1'b1);
        @(negedge clk); btn = 4'b0100;
        cyc(2);
        check("R2 not yet after two edges", {locked, win}, '0);
        cyc(1);
        check("R2 winner after third edge", {locked, win}, {1'b1, 4'b0100});
        check("R6 locked with winner", {4'b0, locked}, 5'b1);
    endtask

    task automatic t_hold_lockout();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); btn[2] = ~btn[2];
        end
        btn = '0; cyc(4);
        check("R3 bounce and release keep winner", {locked, win}, {1'b1, 4'b0100});
        @(negedge clk); btn = 4'b1011; cyc(5);
        check("R4 other presses ignored", {locked, win}, {1'b1, 4'b0100});
        btn = '0;
        set_qm(1'b0);
        check("R7 clear empties winner", {locked, win}, '0);
        check("R6 locked low when empty", {4'b0, locked}, 5'b0);
    endtask

    task automatic t_clear_blocks();
        @(negedge clk); btn = 4'b1000; cyc(6);
        check("R7 no latch while cleared", {locked, win}, '0);
        btn = '0; cyc(3);
        set_qm(1'b1);
        check("R9 arming alone sets nothing", {locked, win}, '0);
    endtask

    task automatic t_simultaneous();
        @(negedge clk); btn = 4'b1010; cyc(3);
        check("R5 lowest index wins", {locked, win}, {1'b1, 4'b0010});
        btn = '0; set_qm(1'b0);
        set_qm(1'b1);
        @(negedge clk); btn = 4'b1111; cyc(3);
        check("R5 all pressed picks player 0", {locked, win}, {1'b1, 4'b0001});
        btn = '0; cyc(2);
    endtask

    task automatic t_filter();
        @(negedge clk); qm = 1'b0; cyc(FILT - 1);
        qm = 1'b1; cyc(SETTLE);
        check("R8 short clear pulse ignored", {locked, win}, {1'b1, 4'b0001});
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); qm = ~qm;
        end
        qm = 1'b1; cyc(SETTLE);
        check("R8 fast bounce ignored", {locked, win}, {1'b1, 4'b0001});
        @(negedge clk); qm = 1'b0; cyc(FILT);
        qm = 1'b1; cyc(SETTLE);
        check("R8 full-window clear accepted", {locked, win}, '0);
        @(negedge clk); btn = 4'b0010; cyc(3);
        check("R8 re-armed after pulse", {locked, win}, {1'b1, 4'b0010});
        btn = '0; set_qm(1'b0);
    endtask

    task automatic t_qm_toggle_only();
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); qm = ~qm;
            if (i % 5 == 0) cyc(FILT + 3);
        end
        qm = 1'b1; cyc(SETTLE);
        check("R9 toggling alone sets no winner", {locked, win}, '0);
        set_qm(1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1;
        check("R1 reset asserted", {locked, win}, '0);
        cyc(3);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_first_press();
        t_hold_lockout();
        t_clear_blocks();
        t_simultaneous();
        t_filter();
        t_qm_toggle_only();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule